// File: doc/BRIEF.md
# Slot-Table Bus Arbiter with Per-Slot Throttling

The block shares one system bus among up to sixteen masters by time division. A table of sixteen channel slots is programmed through a 128-bit configuration input. A pointer walks this table. When the bus is free, the arbiter looks for the first eligible slot at or after the pointer. A slot is eligible when it is enabled and its owning master is requesting. The arbiter grants that master and moves the pointer past the winning slot. A master that owns several slots gets a proportionally larger share. Its slots should sit evenly spaced in the table so that its turns are spread out.

Each slot also carries a two-bit reduction code. When other masters are competing, the code lets the slot's master win only some of the visits to that slot. A lone requester is never held back. A grant stays asserted until the bus signals that the transfer is complete. Requests are plain level signals: a master keeps its request high while it wants the bus. Back-pressure works through the grant: a master waits while another master holds the bus, and the hold lasts until `xfer_done` is seen high.

Top module: `slot_arbiter`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `gnt_valid` is 0 and `gnt` is 0. Every visit counter clears and the pointer returns to slot 0.
- R2: Slot s occupies `cfg_table[127-8*s -: 8]`, so slot 0 is bits [127:120] and slot 15 is bits [7:0]. Within an entry, bit 7 is the enable, bit 6 is reserved (written 0, ignored), bits 5:4 are the reduction code and bits 3:0 are the owning master index.
- R3: A slot whose enable bit is 0 never produces a grant, even when its owner is the only requester.
- R4: In a clock cycle where no grant is held, the arbiter grants the owner of the first eligible slot, scanning from the pointer upward with wrap. A slot whose owner is not requesting, or is throttled, is skipped within the same cycle. The grant appears after that clock edge.
- R5: After a grant from slot w, the pointer becomes w+1 modulo 16. If no slot is eligible, there is no grant and the pointer is unchanged.
- R6: A grant is held with `gnt` and `gnt_idx` stable until a clock edge where `xfer_done` is 1. The grant drops after that edge, and the next arbitration takes place at the following edge.
- R7: Each slot has a 2-bit visit counter. During an arbitration, every slot from the pointer up to and including the winner (all slots if there is no winner) advances its counter modulo 4 if it is enabled, its owner is requesting, and another master is also requesting. Such a slot may win only if its counter, taken before the advance, is below its quota. The quotas are: code 00 → 4 (100%), 01 → 3 (75%), 10 → 2 (50%), 11 → 1 (25%).
- R8: When the owner of a slot is the only requesting master, the slot is never throttled, whatever its code.
- R9: While `gnt_valid` is 1, `gnt` is one-hot with the set bit at `gnt_idx`, and the granted master was requesting at the arbitration edge. While `gnt_valid` is 0, `gnt` is all zeros.
- R10: Under full load, each master's share of grants is proportional to the number of enabled slots it owns, scaled by each slot's quota out of 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 16 | Request level per master |
| xfer_done | input | 1 | Current transfer completes at this edge |
| cfg_table | input | 128 | Sixteen 8-bit slot entries, slot 0 in the top byte |
| gnt | output | 16 | One-hot grant |
| gnt_valid | output | 1 | A grant is currently held |
| gnt_idx | output | 4 | Index of the granted master |

## Verification
The assertions assume that `cfg_table` changes only while no grant is held, and that `xfer_done` carries meaning only while a grant is held. The stimulus reprograms the table only after the grant has dropped and before the next arbitration edge. It drives `xfer_done` freely, because the design ignores it while idle. A behavioural reference model replays the scan, the visit counters and the pointer every clock. The grant shares under full load are then compared against the slot counts and quotas, with a tolerance of one table rotation.

// File: rtl/slot_arb_pkg.sv
package slot_arb_pkg;

  typedef struct packed {
    logic       en;
    logic       rsv;
    logic [1:0] cut;
    logic [3:0] owner;
  } slot_ent_t;

  // number of winnable visits out of four for a reduction code
  function automatic logic [2:0] quota(input logic [1:0] cut);
    return 3'd4 - {1'b0, cut};
  endfunction

endpackage

// File: rtl/slot_eval.sv
module slot_eval
  import slot_arb_pkg::*;
#(
  parameter int SLOT_W = 4,
  parameter int MST_W  = 4,
  localparam int NSLOT = 1 << SLOT_W,
  localparam int NMST  = 1 << MST_W
) (
  input  logic [NSLOT*8-1:0]          cfg,
  input  logic [NMST-1:0]             req,
  input  logic [NSLOT-1:0][1:0]       cnt,
  output logic [NSLOT-1:0]            pass,
  output logic [NSLOT-1:0]            touch,
  output logic [NSLOT-1:0][MST_W-1:0] owner
);

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    slot_ent_t  ent;
    logic       live;
    logic       rival;
    logic [NMST-1:0] self_oh;

    assign ent     = slot_ent_t'(cfg[NSLOT*8-1-8*s -: 8]);
    assign self_oh = NMST'(1) << ent.owner[MST_W-1:0];
    assign live    = ent.en & req[ent.owner[MST_W-1:0]];
    assign rival   = |(req & ~self_oh);
    assign owner[s] = ent.owner[MST_W-1:0];
    assign touch[s] = live & rival;
    assign pass[s]  = live & (~rival | ({1'b0, cnt[s]} < quota(ent.cut)));
  end

endmodule

// File: rtl/rot_pick.sv
module rot_pick #(
  parameter int SLOT_W = 4,
  localparam int NSLOT = 1 << SLOT_W
) (
  input  logic [SLOT_W-1:0] ptr,
  input  logic [NSLOT-1:0]  pass,
  input  logic [NSLOT-1:0]  touch,
  output logic              found,
  output logic [SLOT_W-1:0] win,
  output logic [NSLOT-1:0]  bump
);

  logic [2*NSLOT-1:0] rot_dbl;
  logic [NSLOT-1:0]   rp;
  logic [NSLOT-1:0]   scan_r;
  logic [2*NSLOT-1:0] back_dbl;
  logic [SLOT_W-1:0]  pos;

  assign rot_dbl = {pass, pass} >> ptr;
  assign rp      = rot_dbl[NSLOT-1:0];

  always_comb begin
    found = 1'b0;
    pos   = '0;
    for (int k = 0; k < NSLOT; k++) begin
      scan_r[k] = ~found;
      if (!found && rp[k]) begin
        found = 1'b1;
        pos   = SLOT_W'(k);
      end
    end
  end

  assign back_dbl = {scan_r, scan_r} << ptr;
  assign bump     = back_dbl[2*NSLOT-1:NSLOT] & touch;
  assign win      = ptr + pos;

endmodule

// File: rtl/slot_arbiter.sv
module slot_arbiter
  import slot_arb_pkg::*;
#(
  parameter int SLOT_W = 4,
  parameter int MST_W  = 4,
  localparam int NSLOT = 1 << SLOT_W,
  localparam int NMST  = 1 << MST_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NMST-1:0]      req,
  input  logic                 xfer_done,
  input  logic [NSLOT*8-1:0]   cfg_table,
  output logic [NMST-1:0]      gnt,
  output logic                 gnt_valid,
  output logic [MST_W-1:0]     gnt_idx
);

  logic [SLOT_W-1:0]            ptr_q;
  logic [NSLOT-1:0][1:0]        cnt_q;
  logic [NSLOT-1:0]             pass, touch, bump;
  logic [NSLOT-1:0][MST_W-1:0]  owner;
  logic                         found;
  logic [SLOT_W-1:0]            win;
  logic                         arb_now;

  slot_eval #(.SLOT_W(SLOT_W), .MST_W(MST_W)) u_eval (
    .cfg   (cfg_table),
    .req   (req),
    .cnt   (cnt_q),
    .pass  (pass),
    .touch (touch),
    .owner (owner)
  );

  rot_pick #(.SLOT_W(SLOT_W)) u_pick (
    .ptr   (ptr_q),
    .pass  (pass),
    .touch (touch),
    .found (found),
    .win   (win),
    .bump  (bump)
  );

  assign arb_now = ~gnt_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q     <= '0;
      cnt_q     <= '0;
      gnt_valid <= 1'b0;
      gnt       <= '0;
      gnt_idx   <= '0;
    end else if (arb_now) begin
      for (int s = 0; s < NSLOT; s++)
        if (bump[s]) cnt_q[s] <= cnt_q[s] + 2'd1;
      if (found) begin
        ptr_q     <= win + SLOT_W'(1);
        gnt_valid <= 1'b1;
        gnt_idx   <= owner[win];
        gnt       <= NMST'(1) << owner[win];
      end
    end else if (xfer_done) begin
      gnt_valid <= 1'b0;
      gnt       <= '0;
    end
  end

endmodule

// File: rtl/slot_arb_chk.sv
module slot_arb_chk #(
  parameter int MST_W = 4,
  localparam int NMST = 1 << MST_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NMST-1:0]  req,
  input logic             xfer_done,
  input logic [NMST-1:0]  gnt,
  input logic             gnt_valid,
  input logic [MST_W-1:0] gnt_idx
);

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> ($countones(gnt) == 1 && gnt[gnt_idx])); // R9

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt_valid |-> (gnt == '0)); // R9

  AST_HOLD_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && !xfer_done) |=> (gnt_valid && $stable(gnt) && $stable(gnt_idx))); // R6

  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && xfer_done) |=> !gnt_valid); // R6

  AST_GRANT_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt_valid) |-> ((($past(req) >> gnt_idx) & NMST'(1)) != '0)); // R9

endmodule

bind slot_arbiter slot_arb_chk #(.MST_W(MST_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req       (req),
  .xfer_done (xfer_done),
  .gnt       (gnt),
  .gnt_valid (gnt_valid),
  .gnt_idx   (gnt_idx)
);

// File: tb/sim_slot_arbiter.sv
`timescale 1ns/1ps
module sim_slot_arbiter;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [15:0]  req = '0;
  logic         xfer_done = 1'b0;
  logic [127:0] cfg_table = '0;
  logic [15:0]  gnt;
  logic         gnt_valid;
  logic [3:0]   gnt_idx;

  int checks = 0;
  int fails  = 0;

  // reference model state
  int m_ptr;
  int m_cnt[16];
  bit m_busy;
  int m_idx;
  int wins[16];

  always #5 clk = ~clk;

  slot_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .xfer_done(xfer_done),
    .cfg_table(cfg_table), .gnt(gnt), .gnt_valid(gnt_valid), .gnt_idx(gnt_idx)
  );

  function automatic logic [7:0] ent(input bit en, input int cut, input int own);
    return {en, 1'b0, 2'(cut), 4'(own)};
  endfunction

  task automatic put(input int s, input logic [7:0] e);
    cfg_table[127-8*s -: 8] = e;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_step();
    if (!rst_n) begin
      m_ptr = 0; m_busy = 0; m_idx = 0;
      foreach (m_cnt[i]) m_cnt[i] = 0;
    end else if (m_busy) begin
      if (xfer_done) m_busy = 0;
    end else begin
      for (int k = 0; k < 16; k++) begin
        int s = (m_ptr + k) % 16;
        logic [7:0] e = cfg_table[127-8*s -: 8];
        int own = int'(e[3:0]);
        if (e[7] && req[own]) begin
          bit ok = 1;
          if ((req & ~(16'd1 << own)) != 0) begin
            ok = (m_cnt[s] < 4 - int'(e[5:4]));
            m_cnt[s] = (m_cnt[s] + 1) % 4;
          end
          if (ok) begin
            m_busy = 1; m_idx = own; m_ptr = (s + 1) % 16;
            wins[own]++;
            break;
          end
        end
      end
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    if (rst_n) begin
      logic [15:0] eg = m_busy ? (16'd1 << m_idx) : 16'd0;
      chk(gnt_valid == m_busy && gnt == eg && (!m_busy || gnt_idx == 4'(m_idx)),
          "R4 R5 R6 R7 R9 model grant", int'(gnt), int'(eg));
    end
  endtask

  task automatic clr_wins();
    foreach (wins[i]) wins[i] = 0;
  endtask

  task automatic wait_idle();
    xfer_done = 1'b1;
    while (gnt_valid) cyc();
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // table: CPU (0) on even slots 0..10, others on odd slots, 12..15 disabled
    for (int s = 0; s < 12; s += 2) put(s, ent(1, 0, 0));
    put(1, ent(1, 0, 1)); put(3, ent(1, 0, 2)); put(5, ent(1, 0, 6));
    put(7, ent(1, 0, 4)); put(9, ent(1, 0, 5)); put(11, ent(1, 0, 6));
    put(12, ent(0, 0, 3));
    for (int s = 13; s < 16; s++) put(s, ent(0, 0, 0));

    repeat (3) cyc();
    chk(gnt_valid == 0 && gnt == 0, "R1 reset idle", int'(gnt_valid), 0);
    @(negedge clk); rst_n = 1'b1;
    cyc();
    chk(gnt_valid == 0 && gnt == 0, "R1 first cycle idle", int'(gnt_valid), 0);

    // R2 R4 R5: single requester ETx gets slot 3 grant
    req = 16'h0004; xfer_done = 1'b1;
    cyc();
    chk(gnt_valid && gnt_idx == 2, "R2 R4 owner index", int'(gnt_idx), 2);
    wait_idle();

    // R3: only master 3 requests, its slot is disabled
    req = 16'h0008;
    for (int i = 0; i < 20; i++) begin
      cyc();
      chk(!gnt_valid, "R3 disabled slot", int'(gnt_valid), 0);
    end

    // R6: hold while xfer_done low
    req = 16'h0001; xfer_done = 1'b0;
    cyc();
    for (int i = 0; i < 8; i++) begin
      cyc();
      chk(gnt_valid && gnt == 16'h0001, "R6 hold", int'(gnt), 1);
    end
    xfer_done = 1'b1; cyc();
    chk(!gnt_valid, "R6 release", int'(gnt_valid), 0);
    wait_idle();

    // R10: full load, no throttle
    req = 16'h0077; xfer_done = 1'b1; clr_wins();
    while (wins[1] < 20) cyc();
    chk(wins[0] >= 114 && wins[0] <= 126, "R10 cpu share", wins[0], 120);
    chk(wins[6] >= 38 && wins[6] <= 42, "R10 display share", wins[6], 40);
    chk(wins[5] >= 19 && wins[5] <= 21, "R10 periph share", wins[5], 20);
    req = '0; wait_idle();

    // R7: peripheral slot at 25%
    put(9, ent(1, 3, 5));
    req = 16'h0077; clr_wins();
    while (wins[1] < 40) cyc();
    chk(wins[5] >= 9 && wins[5] <= 11, "R7 quarter share", wins[5], 10);
    req = '0; wait_idle();

    // R7: 50%
    put(9, ent(1, 2, 5));
    req = 16'h0077; clr_wins();
    while (wins[1] < 40) cyc();
    chk(wins[5] >= 19 && wins[5] <= 21, "R7 half share", wins[5], 20);
    req = '0; wait_idle();

    // R8: lone requester never throttled
    put(9, ent(1, 3, 5));
    req = 16'h0020; clr_wins();
    for (int i = 0; i < 40; i++) cyc();
    chk(wins[5] >= 19, "R8 lone requester", wins[5], 20);
    req = '0; wait_idle();

    // R7 75% plus random traffic against the model
    put(9, ent(1, 1, 5)); put(7, ent(1, 2, 4));
    for (int i = 0; i < 600; i++) begin
      req = 16'($urandom);
      xfer_done = ($urandom % 3) == 0;
      cyc();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule